// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flag Register

This block performs 8-bit two's-complement addition, subtraction and comparison, and it keeps an 8-bit status register that records the condition flags of the most recent operation. A caller presents two operands, an operation code and a one-cycle valid strobe. On the following clock edge the block registers the arithmetic result and pulses a result write enable, and it also updates carry, zero, negative, overflow, sign and half-carry in the status register. A compare runs the subtraction datapath and updates the flags exactly as a subtract would, but it leaves the result register alone and raises no write enable. Later decision logic reads the flags from the status register.

The two upper status bits are not arithmetic flags. One is a general-purpose stored bit and the other is an interrupt-enable bit. A separate single-bit write port sets or clears them, and arithmetic never touches them. A bit write in the same cycle as an arithmetic operation lands on the same edge as the new flags. The operand width is a parameter with a default of 8. The half-carry position follows the middle of the word.

Top module: `alu_status_unit`

## Requirements
- R1: The status register has this bit layout: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign, bit 5 half-carry, bit 6 stored bit, bit 7 interrupt enable. A synchronous reset (rst high at a rising edge) clears the status register, the result and result_we to 0.
- R2: With op_sel = 0 (add), the registered result equals (opa + opb) mod 256. Carry is 1 exactly when the sum leaves bit 7, that is, when the unsigned sum exceeds 255.
- R3: With op_sel = 1 (subtract), the registered result equals (opa − opb) mod 256. Carry is 1 exactly when a borrow is needed, that is, when opb > opa as unsigned values.
- R4: Zero is 1 exactly when all 8 bits of the computed value are 0.
- R5: Negative is a copy of bit 7 of the computed value.
- R6: Overflow is 1 exactly when the carry into bit 7 differs from the carry out of bit 7. Examples: a positive plus a positive giving a negative, or a positive minus a negative giving a negative.
- R7: Sign is stored as negative XOR overflow.
- R8: Half-carry is 1 when addition carries from bit 3 into bit 4, or when subtraction borrows into bit 3 from bit 4 (opb[3:0] > opa[3:0]).
- R9: With op_sel = 2 (compare), the flags are set exactly as for a subtraction of the same operands. result_we stays 0 and the result register keeps its value.
- R10: result_we is high for exactly one cycle, on the edge after each valid add or subtract. At all other times it is 0.
- R11: When op_valid is low, or when op_sel = 3 (reserved), result, the arithmetic flags and result_we do not change.
- R12: When bit_we is high, bit_val is written to status bit 6 if bit_sel = 0, or to bit 7 if bit_sel = 1. The write takes effect on the next edge together with any concurrent flag update. Arithmetic never changes bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_sel | input | 2 | 0 add, 1 subtract, 2 compare, 3 reserved |
| opa | input | 8 | First operand (minuend for subtract and compare) |
| opb | input | 8 | Second operand (subtrahend for subtract and compare) |
| bit_we | input | 1 | Single status bit write strobe |
| bit_sel | input | 1 | 0 selects bit 6, 1 selects bit 7 |
| bit_val | input | 1 | Value to write into the selected bit |
| result | output | 8 | Registered result of the last add or subtract |
| result_we | output | 1 | One-cycle pulse marking a new result |
| status | output | 8 | Condition flag register |

## Verification
The assertions check, on every cycle, several properties that can be read off the registers alone. Sign always equals negative XOR overflow. Zero and negative agree with a freshly written result. Compare never raises result_we. The register holds when nothing is requested, and bits 6 and 7 move only through the bit-write port. The actual carry, borrow, overflow and half-carry values can only be shown by the bench's scenarios, because they depend on the operands. These scenarios cover the corner operands (wrap to zero, signed overflow in both directions, nibble borrow), compare after subtract, reserved codes, and bit writes that coincide with arithmetic. The bench also runs a long series of pseudo-random operands against its own reference model.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_CMP = 2'd2,
      ALU_RSV = 2'd3
   } alu_op_e;

   localparam int SR_BITS   = 8;
   localparam int ARITH_CNT = 6;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;
   localparam int FLG_S = 4;
   localparam int FLG_H = 5;
   localparam int FLG_T = 6;
   localparam int FLG_I = 7;

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             c_half,
   output logic             c_top_in,
   output logic             c_out
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (a[i] & cy[i]) | (b_eff[i] & cy[i]);
         end
         assign c_half   = cy[HALF];
         assign c_top_in = cy[WIDTH-1];
         assign c_out    = cy[WIDTH];
      end else begin : g_split
         logic [HALF:0]    lo_sum;
         logic [WIDTH-1:0] top_sum;
         logic [WIDTH:0]   full_sum;
         assign lo_sum   = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                           + {{HALF{1'b0}}, sub};
         assign top_sum  = {1'b0, a[WIDTH-2:0]} + {1'b0, b_eff[WIDTH-2:0]}
                           + {{(WIDTH-1){1'b0}}, sub};
         assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
         assign sum      = full_sum[WIDTH-1:0];
         assign c_half   = lo_sum[HALF];
         assign c_top_in = top_sum[WIDTH-1];
         assign c_out    = full_sum[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
   import alu_status_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]     sum,
   input  logic                 sub,
   input  logic                 c_half,
   input  logic                 c_top_in,
   input  logic                 c_out,
   output logic [ARITH_CNT-1:0] aflags
);
   logic neg, ovf;

   always_comb begin
      neg = sum[WIDTH-1];
      ovf = c_top_in ^ c_out;
      aflags        = '0;
      aflags[FLG_C] = sub ? ~c_out : c_out;
      aflags[FLG_Z] = (sum == '0);
      aflags[FLG_N] = neg;
      aflags[FLG_V] = ovf;
      aflags[FLG_S] = neg ^ ovf;
      aflags[FLG_H] = sub ? ~c_half : c_half;
   end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_status_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic [ARITH_CNT-1:0] aflags,
   input  logic                 bit_we,
   input  logic                 bit_sel,
   input  logic                 bit_val,
   output logic [SR_BITS-1:0]   status
);
   logic [SR_BITS-1:0] nxt;

   always_comb begin
      nxt = status;
      if (upd) nxt[ARITH_CNT-1:0] = aflags;
      if (bit_we) begin
         if (bit_sel) nxt[FLG_I] = bit_val;
         else         nxt[FLG_T] = bit_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) status <= '0;
      else     status <= nxt;
   end

   assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!upd && !bit_we) |=> $stable(status));

   assert_ti_port_only_R12: assert property (@(posedge clk) disable iff (rst)
      !bit_we |=> $stable(status[FLG_I:FLG_T]));

   assert_sign_xor_R7: assert property (@(posedge clk) disable iff (rst)
      status[FLG_S] == (status[FLG_N] ^ status[FLG_V]));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import alu_status_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_valid,
   input  logic [1:0]       op_sel,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             bit_we,
   input  logic             bit_sel,
   input  logic             bit_val,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic [7:0]       status
);
   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu_status_unit: WIDTH must be even and at least 4");
      end
   endgenerate

   logic                 is_add, is_sub, is_cmp;
   logic                 do_flags, do_write, sub_mode;
   logic [WIDTH-1:0]     sum;
   logic                 c_half, c_top_in, c_out;
   logic [ARITH_CNT-1:0] aflags;

   assign is_add   = op_sel == ALU_ADD;
   assign is_sub   = op_sel == ALU_SUB;
   assign is_cmp   = op_sel == ALU_CMP;
   assign do_flags = op_valid && (is_add || is_sub || is_cmp);
   assign do_write = op_valid && (is_add || is_sub);
   assign sub_mode = !is_add;

   alu_arith_core #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_core (
      .a(opa), .b(opb), .sub(sub_mode),
      .sum(sum), .c_half(c_half), .c_top_in(c_top_in), .c_out(c_out)
   );

   alu_flag_calc #(.WIDTH(WIDTH)) u_flags (
      .sum(sum), .sub(sub_mode), .c_half(c_half),
      .c_top_in(c_top_in), .c_out(c_out), .aflags(aflags)
   );

   alu_status_reg u_sr (
      .clk(clk), .rst(rst), .upd(do_flags), .aflags(aflags),
      .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val), .status(status)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         result_we <= 1'b0;
      end else begin
         result_we <= do_write;
         if (do_write) result <= sum;
      end
   end

   assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (rst)
      (op_valid && is_cmp) |=> (!result_we && $stable(result)));

   assert_we_single_R10: assert property (@(posedge clk) disable iff (rst)
      !do_write |=> !result_we);

   assert_zero_match_R4: assert property (@(posedge clk) disable iff (rst)
      result_we |-> (status[FLG_Z] == (result == '0)));

   assert_neg_match_R5: assert property (@(posedge clk) disable iff (rst)
      result_we |-> (status[FLG_N] == result[WIDTH-1]));

endmodule

// File: tb/alu_status_unit_test.sv
module alu_status_unit_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] res;
      logic       we;
      logic [7:0] st;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_valid = 1'b0;
   logic [1:0] op_sel = 2'd0;
   logic [7:0] opa = 8'd0, opb = 8'd0;
   logic       bit_we = 1'b0, bit_sel = 1'b0, bit_val = 1'b0;
   logic [7:0] result;
   logic       result_we;
   logic [7:0] status;

   exp_t       sb[$];
   logic [7:0] m_res = 8'd0;
   logic [7:0] m_st  = 8'd0;
   int         total = 0, fails = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_status_unit uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
      .opa(opa), .opb(opb), .bit_we(bit_we), .bit_sel(bit_sel),
      .bit_val(bit_val), .result(result), .result_we(result_we),
      .status(status)
   );

   task automatic push(input logic we, input string tag);
      exp_t e;
      e.res = m_res; e.we = we; e.st = m_st; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; op_valid = 1'b0; bit_we = 1'b0;
      m_res = 8'd0; m_st = 8'd0;
      push(1'b0, "R1");
      @(negedge clk);
      rst = 1'b0;
      push(1'b0, "R1");
   endtask

   task automatic drive(input logic v, input logic [1:0] op,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic bwe, input logic bsel, input logic bval,
                        input string tag);
      logic [8:0] full;
      logic [7:0] r;
      logic       c, h, vf, wr;
      @(negedge clk);
      op_valid = v; op_sel = op; opa = a; opb = b;
      bit_we = bwe; bit_sel = bsel; bit_val = bval;
      wr = 1'b0;
      if (v && op != 2'd3) begin
         if (op == 2'd0) begin
            full = {1'b0, a} + {1'b0, b};
            r  = full[7:0];
            c  = full[8];
            h  = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            vf = (a[7] == b[7]) && (r[7] != a[7]);
         end else begin
            r  = a - b;
            c  = b > a;
            h  = b[3:0] > a[3:0];
            vf = (a[7] != b[7]) && (r[7] != a[7]);
         end
         m_st[0] = c;
         m_st[1] = (r == 8'd0);
         m_st[2] = r[7];
         m_st[3] = vf;
         m_st[4] = r[7] ^ vf;
         m_st[5] = h;
         if (op != 2'd2) begin
            m_res = r;
            wr = 1'b1;
         end
      end
      if (bwe) m_st[6 + int'(bsel)] = bval;
      push(wr, tag);
   endtask

   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (result !== e.res || result_we !== e.we || status !== e.st) begin
            fails++;
            $display("FAIL %s: result=%h we=%b status=%b expected result=%h we=%b status=%b",
                     e.tag, result, result_we, status, e.res, e.we, e.st);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      do_reset();                                                    // R1
      drive(1, 0, 8'h10, 8'h20, 0, 0, 0, "R2 plain add");
      drive(1, 0, 8'hFF, 8'h01, 0, 0, 0, "R2 R4 R8 wrap to zero");
      drive(1, 0, 8'h7F, 8'h01, 0, 0, 0, "R6 R5 pos+pos=neg");
      drive(1, 0, 8'h80, 8'h80, 0, 0, 0, "R6 R7 neg+neg=pos");
      drive(1, 1, 8'h05, 8'h03, 0, 0, 0, "R3 plain sub");
      drive(1, 1, 8'h03, 8'h05, 0, 0, 0, "R3 R8 borrow");
      drive(1, 1, 8'h7F, 8'h80, 0, 0, 0, "R6 pos-neg=neg");
      drive(1, 1, 8'h80, 8'h01, 0, 0, 0, "R6 R7 neg-pos=pos");
      drive(1, 1, 8'h10, 8'h01, 0, 0, 0, "R8 nibble borrow");
      drive(1, 2, 8'h42, 8'h42, 0, 0, 0, "R9 compare equal");
      drive(1, 2, 8'h01, 8'h02, 0, 0, 0, "R9 compare less");
      drive(0, 0, 8'h12, 8'h34, 0, 0, 0, "R11 idle hold");
      drive(1, 3, 8'h00, 8'h00, 0, 0, 0, "R11 reserved op");
      drive(1, 0, 8'h01, 8'h01, 0, 0, 0, "R10 add pulse");
      drive(0, 0, 8'h01, 8'h01, 0, 0, 0, "R10 pulse ends");
      drive(0, 0, 8'h00, 8'h00, 1, 0, 1, "R12 set bit6");
      drive(0, 0, 8'h00, 8'h00, 1, 1, 1, "R12 set bit7");
      drive(1, 1, 8'h00, 8'h01, 0, 0, 0, "R12 arith keeps bits 6/7");
      drive(1, 0, 8'h08, 8'h08, 1, 0, 0, "R12 R8 concurrent write");
      drive(1, 2, 8'h00, 8'h00, 1, 1, 0, "R12 R9 concurrent with compare");
      drive(1, 0, 8'h00, 8'h00, 0, 0, 0, "R4 zero add");
      for (int i = 0; i < 300; i++) begin
         logic [1:0] op;
         op = 2'($urandom_range(0, 3));
         drive(1'($urandom_range(0, 1)), op, 8'($urandom), 8'($urandom),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), "R2 R3 R6 R8 R9 random");
      end
      drive(1, 1, 8'hAA, 8'h55, 0, 0, 0, "R3 R6 before reset");
      do_reset();                                                    // R1 again
      drive(0, 0, 8'h00, 8'h00, 0, 0, 0, "R1 state after reset");
      @(negedge clk);
      op_valid = 1'b0; bit_we = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule